// File: doc/BRIEF.md
# Programmable External Interrupt Edge Detector

This block turns up to six asynchronous external interrupt lines into single-cycle interrupt request pulses for a downstream interrupt controller. Each line is brought into the clock domain through a two-stage synchronizer. A registered copy of the previous synchronized level is then compared with the current level to find transitions. Whether a rising transition, a falling transition, both or neither raises a request is chosen per channel by software.

The choice comes from two 8-bit control registers on a simple memory-mapped bus. One holds a rising-sensitivity bit per channel and the other a falling-sensitivity bit per channel. Bit i of each register belongs to channel i. Software may rewrite a whole byte, or set or clear one bit without disturbing its neighbours. Before handing a pin to another function, software clears both of that channel's bits. While the pair is cleared, the detector guarantees silence on that channel.

Top module: `xint_edge_unit`

## Requirements
- R1: After reset (active-low `rst_n`), both control registers read 0x00 and `irq_pulse` is all zero.
- R2: A byte write (`bus_wr_byte`=1) to address 0xFF48 loads the rising-sensitivity register and to 0xFF49 loads the falling-sensitivity register, bit i controlling channel i; bits 7 and 6 are not stored and always read 0. A read returns on `bus_rdata` in the same cycle the register selected by `bus_addr`.
- R3: A bit write (`bus_wr_bit`=1) changes only bit `bus_bit_idx` of the addressed register, setting it when `bus_bit_set`=1 and clearing it when 0; an index of 6 or 7 changes nothing.
- R4: With a channel's (rising, falling) pair at 00, neither transition of its pin produces a pulse.
- R5: With the pair at 10, only a low-to-high transition produces a pulse.
- R6: With the pair at 01, only a high-to-low transition produces a pulse.
- R7: With the pair at 11, both transitions produce a pulse.
- R8: A qualifying transition that is stable at clock edge k raises that channel's `irq_pulse` bit after clock edge k+2 for exactly one cycle, however long the new level lasts.
- R9: Channels are independent: simultaneous transitions on several pins each pulse only according to their own pair.
- R10: Enabling a channel while its pin sits steady at either level produces no pulse.
- R11: Writes to any address other than 0xFF48 and 0xFF49 change neither register, and reads of such an address return 0x00. When byte and bit writes are requested in the same cycle, the byte write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 6 | Asynchronous external interrupt lines |
| bus_addr | input | 16 | Register address for read and write |
| bus_wr_byte | input | 1 | Whole-byte write strobe |
| bus_wr_bit | input | 1 | Single-bit write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_bit_idx | input | 3 | Bit index for a single-bit write |
| bus_bit_set | input | 1 | Bit write value: 1 sets, 0 clears |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_pulse | output | 6 | One-cycle interrupt request per channel |

## Verification
The hardest situation to reach is a pin that already sits at a new level while its channel is off, followed by enabling the channel. A careless detector would report the stale level as an edge at that moment. The bench parks each pin high with its pair at 00, lets the synchronizer settle, and then writes each of the four modes in turn. It watches several cycles for silence before toggling the pin through both edges. Because this sweep covers every channel in every mode, each enable decision is also tested against its neighbours.

// File: rtl/xint_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the external interrupt edge detector.
// Assumes channel count never exceeds the register width.
package xint_pkg;
    parameter int XINT_CH_DEF   = 6;
    parameter int XINT_REG_W    = 8;
    parameter int XINT_ADDR_W   = 16;
    parameter logic [15:0] XINT_RISE_ADDR = 16'hFF48;
    parameter logic [15:0] XINT_FALL_ADDR = 16'hFF49;

    // Per-channel sensitivity, bit order {rising, falling}
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_FALL = 2'b01,
        MODE_RISE = 2'b10,
        MODE_BOTH = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/xint_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer bank, one chain per channel.
// Assumes inputs are asynchronous single-bit levels; reset value is low.
module xint_sync #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_in,
    output logic [NUM_CH-1:0] lvl_sync
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
        logic meta_q;
        logic stab_q;

        // Shift the raw level through two stages to settle metastability
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= pin_in[i];
                stab_q <= meta_q;
            end
        end

        assign lvl_sync[i] = stab_q;
    end
endmodule

// File: rtl/xint_cfg_regs.sv
`timescale 1ns/1ps
// Rising and falling sensitivity registers with byte and single-bit writes.
// Assumes NUM_CH < REG_W; upper bits are not stored and read back as zero.
// A byte write takes precedence over a bit write in the same cycle.
module xint_cfg_regs #(
    parameter int              NUM_CH    = 6,
    parameter int              REG_W     = 8,
    parameter int              ADDR_W    = 16,
    parameter int              IDX_W     = 3,
    parameter logic [ADDR_W-1:0] RISE_ADDR = 16'hFF48,
    parameter logic [ADDR_W-1:0] FALL_ADDR = 16'hFF49
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_byte,
    input  logic              bus_wr_bit,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [IDX_W-1:0]  bus_bit_idx,
    input  logic              bus_bit_set,
    output logic [NUM_CH-1:0] rise_en,
    output logic [NUM_CH-1:0] fall_en,
    output logic [REG_W-1:0]  bus_rdata
);
    logic              sel_rise;
    logic              sel_fall;
    logic [NUM_CH-1:0] rise_q;
    logic [NUM_CH-1:0] fall_q;
    logic [NUM_CH-1:0] rise_nxt;
    logic [NUM_CH-1:0] fall_nxt;

    assign sel_rise = (bus_addr == RISE_ADDR);
    assign sel_fall = (bus_addr == FALL_ADDR);

    // Compute the next register contents from the write strobes
    always_comb begin
        rise_nxt = rise_q;
        fall_nxt = fall_q;
        if (bus_wr_byte) begin
            if (sel_rise) rise_nxt = bus_wdata[NUM_CH-1:0];
            if (sel_fall) fall_nxt = bus_wdata[NUM_CH-1:0];
        end else if (bus_wr_bit) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_bit_idx == IDX_W'(i)) begin
                    if (sel_rise) rise_nxt[i] = bus_bit_set;
                    if (sel_fall) fall_nxt[i] = bus_bit_set;
                end
            end
        end
    end

    // Hold the sensitivity bits, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            rise_q <= rise_nxt;
            fall_q <= fall_nxt;
        end
    end

    // Return the addressed register zero-extended, zero elsewhere
    always_comb begin
        if (sel_rise)      bus_rdata = REG_W'(rise_q);
        else if (sel_fall) bus_rdata = REG_W'(fall_q);
        else               bus_rdata = '0;
    end

    assign rise_en = rise_q;
    assign fall_en = fall_q;
endmodule

// File: rtl/xint_edge_det.sv
`timescale 1ns/1ps
// Per-channel transition finder and request pulse generator.
// Assumes lvl_sync is already in the clock domain. The previous-level
// register tracks the input on every cycle, also while a channel is off,
// so enabling a channel never sees a stale difference as an edge.
module xint_edge_det #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lvl_sync,
    input  logic [NUM_CH-1:0] rise_en,
    input  logic [NUM_CH-1:0] fall_en,
    output logic [NUM_CH-1:0] irq_pulse
);
    import xint_pkg::*;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic       prev_q;
        logic       irq_q;
        logic       went_up;
        logic       went_down;
        logic       fire;
        edge_mode_e mode;

        assign mode      = edge_mode_e'({rise_en[i], fall_en[i]});
        assign went_up   = lvl_sync[i] & ~prev_q;
        assign went_down = ~lvl_sync[i] & prev_q;

        // Decide whether this cycle's transition qualifies for a request
        always_comb begin
            case (mode)
                MODE_OFF:  fire = 1'b0;
                MODE_FALL: fire = went_down;
                MODE_RISE: fire = went_up;
                MODE_BOTH: fire = went_up | went_down;
                default:   fire = 1'b0;
            endcase
        end

        // Track the previous level and register the one-cycle request
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                irq_q  <= 1'b0;
            end else begin
                prev_q <= lvl_sync[i];
                irq_q  <= fire;
            end
        end

        assign irq_pulse[i] = irq_q;
    end
endmodule

// File: rtl/xint_edge_unit.sv
`timescale 1ns/1ps
// Top of the programmable external interrupt edge detector.
// Assumes a synchronous active-low reset and asynchronous pin inputs.
// Latency from a pin level stable at edge k to the request is two more edges.
module xint_edge_unit #(
    parameter int NUM_CH = xint_pkg::XINT_CH_DEF,
    parameter int REG_W  = xint_pkg::XINT_REG_W,
    parameter int ADDR_W = xint_pkg::XINT_ADDR_W,
    parameter logic [ADDR_W-1:0] RISE_ADDR = xint_pkg::XINT_RISE_ADDR,
    parameter logic [ADDR_W-1:0] FALL_ADDR = xint_pkg::XINT_FALL_ADDR
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         pin_in,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr_byte,
    input  logic                      bus_wr_bit,
    input  logic [REG_W-1:0]          bus_wdata,
    input  logic [$clog2(REG_W)-1:0]  bus_bit_idx,
    input  logic                      bus_bit_set,
    output logic [REG_W-1:0]          bus_rdata,
    output logic [NUM_CH-1:0]         irq_pulse
);
    localparam int IDX_W = $clog2(REG_W);

    logic [NUM_CH-1:0] lvl_sync;
    logic [NUM_CH-1:0] rise_en_q;
    logic [NUM_CH-1:0] fall_en_q;

    xint_sync #(
        .NUM_CH (NUM_CH)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .lvl_sync (lvl_sync)
    );

    xint_cfg_regs #(
        .NUM_CH    (NUM_CH),
        .REG_W     (REG_W),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .RISE_ADDR (RISE_ADDR),
        .FALL_ADDR (FALL_ADDR)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_byte (bus_wr_byte),
        .bus_wr_bit  (bus_wr_bit),
        .bus_wdata   (bus_wdata),
        .bus_bit_idx (bus_bit_idx),
        .bus_bit_set (bus_bit_set),
        .rise_en     (rise_en_q),
        .fall_en     (fall_en_q),
        .bus_rdata   (bus_rdata)
    );

    xint_edge_det #(
        .NUM_CH (NUM_CH)
    ) det_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_sync  (lvl_sync),
        .rise_en   (rise_en_q),
        .fall_en   (fall_en_q),
        .irq_pulse (irq_pulse)
    );
endmodule

// File: rtl/xint_edge_unit_chk.sv
`timescale 1ns/1ps
// Assertion checker for xint_edge_unit, attached by bind.
// Assumes the same parameters as the instance it watches.
module xint_edge_unit_chk #(
    parameter int NUM_CH = 6,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RISE_ADDR = 16'hFF48,
    parameter logic [ADDR_W-1:0] FALL_ADDR = 16'hFF49
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        pin_in,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr_byte,
    input logic                     bus_wr_bit,
    input logic [REG_W-1:0]         bus_wdata,
    input logic [$clog2(REG_W)-1:0] bus_bit_idx,
    input logic                     bus_bit_set,
    input logic [NUM_CH-1:0]        irq_pulse,
    input logic [NUM_CH-1:0]        rise_en_q,
    input logic [NUM_CH-1:0]        fall_en_q
);
    localparam int IDX_W = $clog2(REG_W);

    AST_RISE_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_byte && bus_addr == RISE_ADDR |=> rise_en_q == $past(bus_wdata[NUM_CH-1:0])); // R2
    AST_FALL_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_byte && bus_addr == FALL_ADDR |=> fall_en_q == $past(bus_wdata[NUM_CH-1:0])); // R2

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        AST_BIT_WRITE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_wr_byte && bus_wr_bit && bus_addr == RISE_ADDR && bus_bit_idx == IDX_W'(i)
            |=> rise_en_q[i] == $past(bus_bit_set)); // R3
        AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pulse[i] |-> $past(rise_en_q[i]) || $past(fall_en_q[i])); // R4
        AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pulse[i] && $past(pin_in[i], 3) |-> $past(rise_en_q[i])); // R5
        AST_FALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pulse[i] && !$past(pin_in[i], 3) |-> $past(fall_en_q[i])); // R6
        AST_PULSE_FROM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pulse[i] |-> $past(pin_in[i], 3) != $past(pin_in[i], 4)); // R8
    end
endmodule

bind xint_edge_unit xint_edge_unit_chk #(
    .NUM_CH    (NUM_CH),
    .REG_W     (REG_W),
    .ADDR_W    (ADDR_W),
    .RISE_ADDR (RISE_ADDR),
    .FALL_ADDR (FALL_ADDR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in      (pin_in),
    .bus_addr    (bus_addr),
    .bus_wr_byte (bus_wr_byte),
    .bus_wr_bit  (bus_wr_bit),
    .bus_wdata   (bus_wdata),
    .bus_bit_idx (bus_bit_idx),
    .bus_bit_set (bus_bit_set),
    .irq_pulse   (irq_pulse),
    .rise_en_q   (rise_en_q),
    .fall_en_q   (fall_en_q)
);

// File: tb/xint_edge_unit_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: register access checks, then a sweep of every
// mode on every channel, then a mixed multi-channel pattern.
module xint_edge_unit_tb_top;
    localparam int NCH = 6;
    localparam logic [15:0] A_RISE = 16'hFF48;
    localparam logic [15:0] A_FALL = 16'hFF49;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin_in = '0;
    logic [15:0]    bus_addr = '0;
    logic           bus_wr_byte = 1'b0;
    logic           bus_wr_bit = 1'b0;
    logic [7:0]     bus_wdata = '0;
    logic [2:0]     bus_bit_idx = '0;
    logic           bus_bit_set = 1'b0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] irq_pulse;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    xint_edge_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .bus_addr    (bus_addr),
        .bus_wr_byte (bus_wr_byte),
        .bus_wr_bit  (bus_wr_bit),
        .bus_wdata   (bus_wdata),
        .bus_bit_idx (bus_bit_idx),
        .bus_bit_set (bus_bit_set),
        .bus_rdata   (bus_rdata),
        .irq_pulse   (irq_pulse)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_byte = 1'b1;
        @(negedge clk);
        bus_wr_byte = 1'b0;
    endtask

    task automatic wr_bit(input logic [15:0] a, input logic [2:0] idx, input logic s);
        @(negedge clk);
        bus_addr = a; bus_bit_idx = idx; bus_bit_set = s; bus_wr_bit = 1'b1;
        @(negedge clk);
        bus_wr_bit = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // Idle cycles expecting no request at all
    task automatic quiet(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check(req, 8'(irq_pulse), 8'h00);
        end
    endtask

    // Drive new pin levels, then expect the pulse vector only in cycle 3
    task automatic drive_pins(input string req, input logic [NCH-1:0] lvl,
                              input logic [NCH-1:0] exp_vec);
        @(negedge clk);
        pin_in = lvl;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            check(req, 8'(irq_pulse), (c == 3) ? 8'(exp_vec) : 8'h00);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", 8'(irq_pulse), 8'h00);
        rd_check("R1 rise", A_RISE, 8'h00);
        rd_check("R1 fall", A_FALL, 8'h00);

        // R2: byte writes, upper bits dropped
        wr_byte(A_RISE, 8'hFF);
        rd_check("R2 rise", A_RISE, 8'h3F);
        wr_byte(A_FALL, 8'hA5);
        rd_check("R2 fall", A_FALL, 8'h25);
        rd_check("R2 rise kept", A_RISE, 8'h3F);

        // R3: single-bit set and clear
        wr_byte(A_RISE, 8'h00);
        wr_bit(A_RISE, 3'd2, 1'b1);
        rd_check("R3 set2", A_RISE, 8'h04);
        wr_bit(A_RISE, 3'd5, 1'b1);
        rd_check("R3 set5", A_RISE, 8'h24);
        wr_bit(A_RISE, 3'd2, 1'b0);
        rd_check("R3 clr2", A_RISE, 8'h20);
        wr_bit(A_RISE, 3'd6, 1'b1);
        rd_check("R3 idx6", A_RISE, 8'h20);
        wr_bit(A_RISE, 3'd7, 1'b1);
        rd_check("R3 idx7", A_RISE, 8'h20);
        wr_bit(A_FALL, 3'd0, 1'b0);
        rd_check("R3 fall clr0", A_FALL, 8'h24);
        rd_check("R3 rise untouched", A_RISE, 8'h20);

        // R11: other addresses and strobe priority
        wr_byte(16'hFF4A, 8'h3F);
        rd_check("R11 rise", A_RISE, 8'h20);
        rd_check("R11 fall", A_FALL, 8'h24);
        rd_check("R11 unmapped", 16'hFF4A, 8'h00);
        wr_bit(16'hFF47, 3'd0, 1'b1);
        rd_check("R11 rise bit", A_RISE, 8'h20);
        @(negedge clk);
        bus_addr = A_RISE; bus_wdata = 8'h10; bus_wr_byte = 1'b1;
        bus_bit_idx = 3'd0; bus_bit_set = 1'b1; bus_wr_bit = 1'b1;
        @(negedge clk);
        bus_wr_byte = 1'b0; bus_wr_bit = 1'b0;
        rd_check("R11 byte wins", A_RISE, 8'h10);

        // R4 R5 R6 R7 R10: every mode on every channel
        for (int m = 0; m < 4; m++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                logic [NCH-1:0] bit_v;
                logic [NCH-1:0] up_exp;
                logic [NCH-1:0] dn_exp;
                bit_v  = NCH'(1) << ch;
                up_exp = (m >= 2) ? bit_v : '0;
                dn_exp = (m % 2 == 1) ? bit_v : '0;
                wr_byte(A_RISE, 8'h00);
                wr_byte(A_FALL, 8'h00);
                pin_in = bit_v;
                quiet("R4 off park", 5);
                wr_byte(A_RISE, (m >= 2) ? 8'(bit_v) : 8'h00);
                wr_byte(A_FALL, (m % 2 == 1) ? 8'(bit_v) : 8'h00);
                quiet("R10 enable high", 4);
                drive_pins("R6 fall", '0, dn_exp);
                drive_pins("R5 rise", bit_v, up_exp);
                drive_pins("R7 fall again", '0, dn_exp);
                quiet("R10 low hold", 3);
            end
        end

        // R8: held level gives only one pulse
        wr_byte(A_RISE, 8'h3F);
        wr_byte(A_FALL, 8'h00);
        drive_pins("R8 long high", 6'h01, 6'h01);
        quiet("R8 no repeat", 10);

        // R9: mixed per-channel modes, simultaneous transitions
        wr_byte(A_RISE, 8'h0F);
        wr_byte(A_FALL, 8'h3A);
        drive_pins("R9 all low", 6'h00, 6'h3A & 6'h01);
        drive_pins("R9 all high", 6'h3F, 6'h0F);
        drive_pins("R9 all low2", 6'h00, 6'h3A);
        drive_pins("R9 partial", 6'h15, 6'h05);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule